// File: doc/BRIEF.md
# Sparse Ling Parallel-Prefix Adder

This block adds two unsigned operands of a parameterizable even width (64 bits by default) and returns the sum together with a carry-out. The incoming carry of the whole adder is tied to zero. Carries are not propagated directly. Instead, a pseudo-carry is resolved on a minimum-depth Kogge-Stone tree with fan-in two. The pseudo-carry does not include the transmit term of its own bit. The tree works only on the top bit of every 2-bit group, so it has half the width of a full tree.

The first combine level is merged with the bitwise logic. For each pair of adjacent bits, the pseudo-carry is the OR of their two generate bits, and the pair's transmit is the AND of the two transmit bits just below the pair. Transmit is always the OR of the operand bits, never the XOR. Each 2-bit group precomputes its two sum bits twice, once for a carry coming in and once for no carry. The pseudo-carry arriving from the group below, combined with the transmit bit directly below the group, picks one of the two sets. The carry-out is chosen in the same way, from the topmost pseudo-carry.

An optional output register (`REG_OUT`) holds the sum and carry-out for one cycle. The reset is active-low and synchronous and clears that register. With `REG_OUT = 0`, the outputs follow the operands combinationally and the clock and reset only time the checks.

Top module: `ling_sparse_adder`

## Requirements
- R1: `sum` equals (`a` + `b`) modulo 2^WIDTH for every operand pair.
- R2: `cout` equals bit WIDTH of the (WIDTH+1)-bit sum `a` + `b`.
- R3: With `REG_OUT = 1`, `sum` and `cout` read zero while `rst_n` is low. After reset, they show the result of the operands present at the previous rising clock edge.
- R4: For every 2-bit group k, the real carry out of bit 2k+1 equals the group's prefix pseudo-carry ANDed with the transmit (OR) of bit 2k+1. A pseudo-carry that meets a zero transmit bit must therefore produce no carry, so a carry absorbed at a group's top bit leaves the next group's sum bits uncarried.
- R5: The carry into bit 0 is zero, so `sum[0]` equals `a[0]` XOR `b[0]`.
- R6: All-ones plus one carries across the full width: `sum` is zero and `cout` is one.
- R7: Operands with complementary alternating bit patterns (transmit everywhere, generate nowhere) give an all-ones sum and a zero carry-out.
- R8: A 16-bit instance without the output register gives the same arithmetic results in the same cycle as its inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| sum | output | WIDTH | Sum, modulo 2^WIDTH |
| cout | output | 1 | Carry out of the top bit |

## Verification
All-ones plus one drives a carry through every group and through every level of the tree. It exposes a broken span in the prefix network or a wrong final select. Complementary alternating patterns set transmit everywhere with no generate, so any carry that appears from nowhere shows up as a cleared sum bit. A small operand with a generate at bit 0 and a zero transmit at bit 1 separates the pseudo-carry from the real carry. If the transmit AND is missing, this vector gives a wrong sum. Random operand pairs on the 64-bit registered instance and the 16-bit combinational instance cover the mixed cases, and each instance is checked in its own latency.

// File: rtl/ling_pkg.sv
package ling_pkg;

    // Pseudo-carry / transmit pair carried through the prefix network
    typedef struct packed {
        logic h;
        logic t;
    } ht_t;

    // Associative combine: upper span over lower span
    function automatic ht_t ht_combine(input ht_t hi, input ht_t lo);
        ht_t r;
        r.h = hi.h | (hi.t & lo.h);
        r.t = hi.t & lo.t;
        return r;
    endfunction

endpackage

// File: rtl/ling_pair_stage.sv
// Merged bitwise + first recurrence level: one (h,t) pair per 2-bit group.
module ling_pair_stage #(
    parameter int WIDTH = 64,
    localparam int NG = WIDTH / 2
) (
    input  logic [WIDTH-1:0]          a,
    input  logic [WIDTH-1:0]          b,
    output logic [WIDTH-1:0]          tx,
    output ling_pkg::ht_t [NG-1:0]    grp
);
    logic [WIDTH-1:0] gen;

    assign gen = a & b;
    assign tx  = a | b;

    for (genvar k = 0; k < NG; k++) begin : g_pair
        assign grp[k].h = gen[2*k+1] | gen[2*k];
        if (k == 0) begin : g_low
            // nothing below bit 0: carry-in is zero
            assign grp[k].t = 1'b0;
        end else begin : g_mid
            assign grp[k].t = tx[2*k] & tx[2*k-1];
        end
    end
endmodule

// File: rtl/ling_kogge_tree.sv
// Minimum-depth Kogge-Stone prefix over group pairs, fan-in two per cell.
module ling_kogge_tree #(
    parameter int NG = 32,
    localparam int LEVELS = (NG > 1) ? $clog2(NG) : 1
) (
    input  ling_pkg::ht_t [NG-1:0] leaf,
    output ling_pkg::ht_t [NG-1:0] pref
);
    ling_pkg::ht_t [NG-1:0] lvl [LEVELS+1];

    assign lvl[0] = leaf;

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int SPAN = 1 << l;
        for (genvar k = 0; k < NG; k++) begin : g_cell
            if (k >= SPAN) begin : g_op
                assign lvl[l+1][k] = ling_pkg::ht_combine(lvl[l][k], lvl[l][k-SPAN]);
            end else begin : g_buf
                assign lvl[l+1][k] = lvl[l][k];
            end
        end
    end

    assign pref = lvl[LEVELS];
endmodule

// File: rtl/ling_cond_group.sv
// 2-bit conditional sum block selected by the incoming pseudo-carry.
module ling_cond_group (
    input  logic [1:0] a2,
    input  logic [1:0] b2,
    input  logic       t_below,
    input  logic       h_in,
    output logic [1:0] s2
);
    logic [1:0] half;
    logic       g_lo;
    logic       t_lo;
    logic [1:0] s_nc;
    logic [1:0] s_wc;
    logic [1:0] s_hp;

    assign half = a2 ^ b2;
    assign g_lo = a2[0] & b2[0];
    assign t_lo = a2[0] | b2[0];

    // carry-in 0 / carry-in 1 candidates
    assign s_nc = {half[1] ^ g_lo, half[0]};
    assign s_wc = {half[1] ^ t_lo, ~half[0]};

    // pseudo-carry high: real carry exists only if the bit below transmits
    assign s_hp = t_below ? s_wc : s_nc;
    assign s2   = h_in ? s_hp : s_nc;
endmodule

// File: rtl/ling_sparse_adder.sv
module ling_sparse_adder #(
    parameter int WIDTH   = 64,
    parameter bit REG_OUT = 1'b1,
    localparam int NG = WIDTH / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH-1:0]       tx;
    ling_pkg::ht_t [NG-1:0] grp;
    ling_pkg::ht_t [NG-1:0] pref;
    logic [WIDTH-1:0]       sum_c;
    logic                   cout_c;

    ling_pair_stage #(.WIDTH(WIDTH)) u_pair (
        .a   (a),
        .b   (b),
        .tx  (tx),
        .grp (grp)
    );

    ling_kogge_tree #(.NG(NG)) u_tree (
        .leaf (grp),
        .pref (pref)
    );

    for (genvar k = 0; k < NG; k++) begin : g_sum
        if (k == 0) begin : g_first
            ling_cond_group u_grp (
                .a2      (a[1:0]),
                .b2      (b[1:0]),
                .t_below (1'b0),
                .h_in    (1'b0),
                .s2      (sum_c[1:0])
            );
        end else begin : g_rest
            ling_cond_group u_grp (
                .a2      (a[2*k+1:2*k]),
                .b2      (b[2*k+1:2*k]),
                .t_below (tx[2*k-1]),
                .h_in    (pref[k-1].h),
                .s2      (sum_c[2*k+1:2*k])
            );
        end
    end

    // carry-out: conditional value selected by the top pseudo-carry
    assign cout_c = pref[NG-1].h ? tx[WIDTH-1] : 1'b0;

    logic [WIDTH:0] ref_w;
    assign ref_w = {1'b0, a} + {1'b0, b};

    if (REG_OUT) begin : g_reg
        logic primed;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum    <= '0;
                cout   <= 1'b0;
                primed <= 1'b0;
            end else begin
                sum    <= sum_c;
                cout   <= cout_c;
                primed <= 1'b1;
            end
        end

        assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> (sum == $past(ref_w[WIDTH-1:0])));
        assert_cout_R2: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> (cout == $past(ref_w[WIDTH])));
    end else begin : g_comb
        assign sum  = sum_c;
        assign cout = cout_c;

        assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
            sum == ref_w[WIDTH-1:0]);
        assert_cout_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cout == ref_w[WIDTH]);
    end

    assert_bit0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sum_c[0] == (a[0] ^ b[0]));

    for (genvar k = 0; k < NG; k++) begin : g_chk
        localparam int LW = 2 * k + 2;
        logic [LW:0] part;
        assign part = {1'b0, a[LW-1:0]} + {1'b0, b[LW-1:0]};
        assert_realcarry_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (pref[k].h & tx[2*k+1]) == part[LW]);
    end
endmodule

// File: tb/sim_ling_sparse_adder.sv
module sim_ling_sparse_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic [63:0] sum0;
    logic        cout0;
    logic [15:0] sum1;
    logic        cout1;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ling_sparse_adder #(.WIDTH(64), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .sum(sum0), .cout(cout0));

    ling_sparse_adder #(.WIDTH(16), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .a(a[15:0]), .b(b[15:0]), .sum(sum1), .cout(cout1));

    function automatic logic [64:0] exp64(input logic [63:0] x, input logic [63:0] y);
        return {1'b0, x} + {1'b0, y};
    endfunction

    function automatic logic [16:0] exp16(input logic [15:0] x, input logic [15:0] y);
        return {1'b0, x} + {1'b0, y};
    endfunction

    task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, registered result visible after next posedge
    task automatic run(input logic [63:0] x, input logic [63:0] y, input string req);
        logic [64:0] e;
        logic [16:0] e1;
        @(negedge clk);
        a = x;
        b = y;
        @(posedge clk);
        #2;
        e  = exp64(x, y);
        e1 = exp16(x[15:0], y[15:0]);
        chk({req, " sum R1"}, {1'b0, sum0}, {1'b0, e[63:0]});
        chk({req, " cout R2"}, {64'd0, cout0}, {64'd0, e[64]});
        chk({req, " narrow R8"}, {48'd0, cout1, sum1}, {48'd0, e1});
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        a = 64'hFFFF_FFFF_FFFF_FFFF;
        b = 64'h1;
        @(negedge clk);
        chk("reset R3", {cout0, sum0}, 65'd0);
        rst_n = 1'b1;

        run(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "allones+1 R6");
        chk("allones+1 R6", {cout0, sum0}, {1'b1, 64'd0});
        run(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, "alternating R7");
        chk("alternating R7", {cout0, sum0}, {1'b0, {64{1'b1}}});
        run(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, "alternating R7");
        // generate at bit0, bit1 absorbs: expect 6, bit2 clean
        run(64'h5, 64'h1, "absorb R4");
        chk("absorb R4", {cout0, sum0}, 65'd6);
        run(64'h7FFF_FFFF_FFFF_FFFF, 64'h1, "chain R4");
        run(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "topgen R2");
        chk("topgen R2", {cout0, sum0}, {1'b1, 64'd0});
        run(64'h0000_0000_0000_0003, 64'h0000_0000_0000_0001, "bit0 R5");
        chk("bit0 R5", {63'd0, sum0[1:0]}, 65'd0);
        run(64'h0, 64'h0, "zero R1");

        for (int i = 0; i < 300; i++) begin
            run({$urandom, $urandom}, {$urandom, $urandom}, "random");
        end

        // one-cycle latency: hold new operands, output lags by one edge
        @(negedge clk);
        a = 64'd10;
        b = 64'd20;
        @(posedge clk);
        #2;
        chk("latency R3", {cout0, sum0}, 65'd30);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule